// File: doc/BRIEF.md
# Bidirectional Sequential Channel Loader

This block gathers 12-bit pixel words from two input buses and deposits them, one or two at a time, into a bank of twelve per-channel holding registers. When the bank is full, a transfer request copies all twelve words into a second bank of output registers. The edge that performs the copy also begins filling the holding bank again, so a display pipeline can stream frames without a gap. Bus A serves the even channels and bus B the odd channels. A direction input runs the fill from the lowest channel upward or from the highest channel downward, which mirrors the image.

Two loading modes exist. In dual-bus mode both buses deliver a word on every rising edge of the pixel clock. In single-bus mode one word arrives on each edge of the pixel clock, rising and falling. Both edges are handled synchronously. The block runs on a clock at twice the pixel rate, and a phase input marks which ticks stand for rising pixel-clock edges. Either mode fills the twelve channels in six pixel-clock cycles.

Top module: `chan_seq_loader`

## Requirements
- R1: While reset is asserted, and until the first transfer, all holding and output registers read zero and no loading takes place. A transfer with nothing loaded therefore presents twelve zero words.
- R2: A transfer is requested when `xfer_req` is high on a rising slot (`rise_tick` = 1). On the next rising slot, `out_words` takes the twelve words held before that edge.
- R3: The rising slot that performs a transfer also starts a new sequence and captures its first word (single mode) or first two words (dual mode).
- R4: Channels 0, 2, …, 10 are written only from `bus_a`, and channels 1, 3, …, 11 only from `bus_b`. Channel c occupies bits [12c+11:12c] of `out_words`, with bit 11 of each word as its MSB.
- R5: With `dir_dn` = 0, word k of a sequence goes to channel k. With `dir_dn` = 1, it goes to channel 11−k.
- R6: With `dual_mode` = 1, words 2p and 2p+1 are both captured on the p-th rising slot of the sequence. Nothing is captured on falling slots.
- R7: With `dual_mode` = 0, word 2p is captured on the p-th rising slot and word 2p+1 on the falling slot that follows. As a result, bus A is sampled on rising slots when `dir_dn` = 0 and on falling slots when `dir_dn` = 1.
- R8: Words presented after the twelfth word of a sequence, and before the next transfer, are not stored. `out_words` changes only on a transfer edge.
- R9: `xfer_req` high on a falling slot has no effect.
- R10: The mode and direction in force on the transfer edge govern the whole sequence. Later changes of `dual_mode` or `dir_dn` apply only from the next sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rise_tick | input | 1 | 1 on ticks standing for a rising pixel-clock edge, 0 on falling; alternates every tick |
| xfer_req | input | 1 | Transfer / start request |
| dual_mode | input | 1 | 1 = dual-bus loading, 0 = single-bus double-edge loading |
| dir_dn | input | 1 | 0 = fill upward from channel 0, 1 = fill downward from channel 11 |
| bus_a | input | 12 | Word bus for even channels |
| bus_b | input | 12 | Word bus for odd channels |
| out_words | output | 144 | Twelve transferred 12-bit words, channel c at bits [12c+11:12c] |

## Verification
One edge can both copy the finished frame to the outputs and store the first words of the next frame. A second edge, the last loading edge of a sequence, can also be the one that samples the next transfer request. The bench provokes both by raising the request on the final rising slot of one sequence and starting the next sequence on the very next rising slot, in both modes and both directions. The outputs must show only the completed previous frame. The words captured on that shared edge must surface intact at the following transfer, which shows that neither action corrupted the other.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

  typedef enum logic {
    LOAD_UP   = 1'b0,
    LOAD_DOWN = 1'b1
  } load_dir_e;

  typedef enum logic {
    BUS_SINGLE = 1'b0,
    BUS_DUAL   = 1'b1
  } bus_mode_e;

endpackage

// File: rtl/csl_reset_sync.sv
module csl_reset_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[1];

endmodule

// File: rtl/csl_seq_ctrl.sv
module csl_seq_ctrl
  import chan_seq_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise_tick,
  input  logic           xfer_req,
  input  logic           dual_mode,
  input  logic           dir_dn,
  output logic           start,
  output logic [NCH-1:0] wr_en
);

  localparam int CW = $clog2(NCH + 1);
  typedef logic [CW:0] idx_t;
  localparam logic [CW-1:0] LIMIT = CW'(NCH);

  logic           strobe_q, strobe_nxt;
  logic [CW-1:0]  cnt_q, cnt_nxt;
  bus_mode_e      mode_q, mode_nxt, mode_eff;
  load_dir_e      dir_q, dir_nxt, dir_eff;
  idx_t           k_ext, k_pair, step;
  logic           load_ok;

  // next-state logic
  always_comb begin
    start    = rise_tick & strobe_q;
    mode_eff = start ? bus_mode_e'(dual_mode) : mode_q;
    dir_eff  = start ? load_dir_e'(dir_dn) : dir_q;
    k_ext    = start ? '0 : {1'b0, cnt_q};
    k_pair   = k_ext + idx_t'(1);
    step     = (mode_eff == BUS_DUAL) ? idx_t'(2) : idx_t'(1);
    load_ok  = start |
               ((cnt_q < LIMIT) & (rise_tick | (mode_eff == BUS_SINGLE)));

    strobe_nxt = rise_tick ? xfer_req : strobe_q;
    cnt_nxt    = load_ok ? CW'(k_ext + step) : cnt_q;
    mode_nxt   = mode_eff;
    dir_nxt    = dir_eff;
  end

  // per-channel write decode
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    localparam idx_t POS_UP = idx_t'(c);
    localparam idx_t POS_DN = idx_t'(NCH - 1 - c);
    idx_t pos_c;
    assign pos_c    = (dir_eff == LOAD_DOWN) ? POS_DN : POS_UP;
    assign wr_en[c] = load_ok &
                      ((pos_c == k_ext) |
                       ((mode_eff == BUS_DUAL) & (pos_c == k_pair)));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt_q    <= LIMIT;
      mode_q   <= BUS_SINGLE;
      dir_q    <= LOAD_UP;
    end else begin
      strobe_q <= strobe_nxt;
      cnt_q    <= cnt_nxt;
      mode_q   <= mode_nxt;
      dir_q    <= dir_nxt;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R6
  dual_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_tick && mode_q == BUS_DUAL) |-> (wr_en == '0));

  // R7
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !rise_tick);

  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) <= 2);

endmodule

// File: rtl/csl_hold_bank.sv
module csl_hold_bank #(
  parameter int NCH = 12,
  parameter int W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        wr_en,
  input  logic [W-1:0]          bus_a,
  input  logic [W-1:0]          bus_b,
  output logic [NCH-1:0][W-1:0] hold_q
);

  logic [NCH-1:0][W-1:0] hold_nxt;

  always_comb begin
    hold_nxt = hold_q;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en[c]) begin
        hold_nxt[c] = (c % 2 == 0) ? bus_a : bus_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_nxt;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[c] |=> $stable(hold_q[c]));
  end

endmodule

// File: rtl/csl_out_bank.sv
module csl_out_bank #(
  parameter int NCH = 12,
  parameter int W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NCH-1:0][W-1:0] hold_in,
  output logic [NCH-1:0][W-1:0] out_q
);

  logic [NCH-1:0][W-1:0] out_nxt;

  always_comb begin
    out_nxt = start ? hold_in : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_nxt;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(out_q));

  // R2
  out_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_q == $past(hold_in)));

endmodule

// File: rtl/chan_seq_loader.sv
module chan_seq_loader
  import chan_seq_pkg::*;
#(
  parameter int NCH = 12,
  parameter int W   = 12
) (
  input  logic               clk2x,
  input  logic               rst_n,
  input  logic               rise_tick,
  input  logic               xfer_req,
  input  logic               dual_mode,
  input  logic               dir_dn,
  input  logic [W-1:0]       bus_a,
  input  logic [W-1:0]       bus_b,
  output logic [NCH*W-1:0]   out_words
);

  logic                  rst_sync_n;
  logic                  start;
  logic [NCH-1:0]        wr_en;
  logic [NCH-1:0][W-1:0] hold_q;
  logic [NCH-1:0][W-1:0] out_q;

  csl_reset_sync u_rst (
    .clk       (clk2x),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  csl_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk2x),
    .rst_n     (rst_sync_n),
    .rise_tick (rise_tick),
    .xfer_req  (xfer_req),
    .dual_mode (dual_mode),
    .dir_dn    (dir_dn),
    .start     (start),
    .wr_en     (wr_en)
  );

  csl_hold_bank #(.NCH(NCH), .W(W)) u_hold (
    .clk    (clk2x),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .bus_a  (bus_a),
    .bus_b  (bus_b),
    .hold_q (hold_q)
  );

  csl_out_bank #(.NCH(NCH), .W(W)) u_out (
    .clk     (clk2x),
    .rst_n   (rst_sync_n),
    .start   (start),
    .hold_in (hold_q),
    .out_q   (out_q)
  );

  assign out_words = out_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk2x)
    !rst_sync_n |=> (out_words == '0));

endmodule

// File: tb/chan_seq_loader_bench.sv
module chan_seq_loader_bench;

  localparam int NCH = 12;
  localparam int W   = 12;
  typedef logic [NCH-1:0][W-1:0] frame_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic               rise_tick;
  logic               xfer_req;
  logic               dual_mode;
  logic               dir_dn;
  logic [W-1:0]       bus_a;
  logic [W-1:0]       bus_b;
  logic [NCH*W-1:0]   out_words;

  chan_seq_loader u_chan_seq_loader (
    .clk2x     (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .xfer_req  (xfer_req),
    .dual_mode (dual_mode),
    .dir_dn    (dir_dn),
    .bus_a     (bus_a),
    .bus_b     (bus_b),
    .out_words (out_words)
  );

  int     n_chk  = 0;
  int     n_fail = 0;
  logic   nxt_rise = 1'b1;
  logic   chk_flag = 1'b0;
  bit     done = 0;
  frame_t mdl = '0;
  frame_t last_exp = '0;
  frame_t exp_q[$];
  string  tag_q[$];

  task automatic check(input bit ok, input string tag,
                       input frame_t act, input frame_t exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic drive_slot(input logic x, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic m, input logic d, input logic chk);
    @(negedge clk);
    rise_tick = nxt_rise;
    nxt_rise  = ~nxt_rise;
    xfer_req  = x;
    bus_a     = a;
    bus_b     = b;
    dual_mode = m;
    dir_dn    = d;
    chk_flag  = chk;
  endtask

  function automatic logic [W-1:0] word_of(input int seed, input int k);
    return W'((seed << 8) | (k + 16));
  endfunction

  function automatic int chan_of(input logic d, input int k);
    return d ? (NCH - 1 - k) : k;
  endfunction

  // place word w for channel ch on its bus (even -> A, odd -> B)
  task automatic put(input int ch, input logic [W-1:0] w,
                     inout logic [W-1:0] a, inout logic [W-1:0] b);
    if (ch % 2 == 0) a = w; else b = w;
    mdl[ch] = w;
  endtask

  task automatic run_frame(input logic m, input logic d, input int seed,
                           input logic pre, input logic end_strobe,
                           input logic flip, input int extra, input string tag);
    if (!pre) begin
      if (!nxt_rise) drive_slot(1'b0, 12'hA11, 12'hA22, m, d, 1'b0);
      drive_slot(1'b1, 12'hA33, 12'hA44, m, d, 1'b0);
      drive_slot(1'b0, 12'hA55, 12'hA66, m, d, 1'b0);
    end
    for (int i = 0; i < NCH / 2; i++) begin
      logic [W-1:0] a, b;
      logic md, dd;
      int k, ca, cb;
      md = (flip && i > 0) ? ~m : m;
      dd = (flip && i > 0) ? ~d : d;
      k  = 2 * i;
      ca = chan_of(d, k);
      cb = chan_of(d, k + 1);
      if (i == 0) begin
        exp_q.push_back(mdl);
        tag_q.push_back(tag);
        last_exp = mdl;
      end
      a = W'(12'hE00 | i);
      b = W'(12'hD00 | i);
      put(ca, word_of(seed, k), a, b);
      if (m) put(cb, word_of(seed, k + 1), a, b);
      drive_slot(end_strobe && (i == NCH / 2 - 1), a, b, md, dd, i == 0);
      a = W'(12'hE80 | i);
      b = W'(12'hD80 | i);
      if (!m) put(cb, word_of(seed, k + 1), a, b);
      drive_slot(1'b0, a, b, md, dd, 1'b0);
    end
    for (int e = 0; e < extra; e++) begin
      drive_slot(1'b0, W'(12'hC00 | e), W'(12'hB00 | e), m, d, 1'b0);
    end
  endtask

  // monitor: compare outputs after each transfer edge
  initial begin
    forever begin
      logic f;
      @(posedge clk);
      f = chk_flag;
      #5;
      if (f) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected transfer", frame_t'(out_words), '0);
        end else begin
          frame_t e;
          string  t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_words === e, t, frame_t'(out_words), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rise_tick = 1'b0; xfer_req = 1'b0; dual_mode = 1'b0; dir_dn = 1'b0;
    bus_a = '0; bus_b = '0;
    for (int i = 0; i < 4; i++) drive_slot(1'b0, 12'h123, 12'h456, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) drive_slot(1'b0, 12'h789, 12'hABC, 1'b0, 1'b0, 1'b0);
    // R1: idle after reset, nothing loaded
    check(out_words === '0, "R1 reset state", frame_t'(out_words), '0);

    // R1 zeros out; single up (R5 R7)
    run_frame(1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, "R1 first transfer zero");
    // single down (R5 R7), extra words afterwards (R8)
    run_frame(1'b0, 1'b1, 2, 1'b0, 1'b0, 1'b0, 6, "R7 single up frame R4");
    @(posedge clk); #5;
    check(out_words === last_exp, "R8 outputs hold between transfers",
          frame_t'(out_words), last_exp);
    // dual up, request on last loading edge (R6 R3)
    run_frame(1'b1, 1'b0, 3, 1'b0, 1'b1, 1'b0, 0, "R8 single down frame extra ignored R5");
    // dual down, back to back
    run_frame(1'b1, 1'b1, 4, 1'b1, 1'b1, 1'b0, 0, "R6 dual up frame R2");
    // single up, back to back, inputs flipped mid-sequence
    run_frame(1'b0, 1'b0, 5, 1'b1, 1'b0, 1'b1, 0, "R3 dual down back to back");
    // R9: request only on a falling slot
    drive_slot(1'b0, 12'h901, 12'h902, 1'b0, 1'b0, 1'b0);
    drive_slot(1'b1, 12'h903, 12'h904, 1'b0, 1'b0, 1'b0);
    drive_slot(1'b0, 12'h905, 12'h906, 1'b0, 1'b0, 1'b0);
    drive_slot(1'b0, 12'h907, 12'h908, 1'b0, 1'b0, 1'b0);
    drive_slot(1'b0, 12'h909, 12'h90A, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #5;
    check(out_words === last_exp, "R9 falling-slot request ignored",
          frame_t'(out_words), last_exp);
    run_frame(1'b1, 1'b0, 6, 1'b0, 1'b0, 1'b1, 2, "R10 single up frame with flipped inputs R3");
    run_frame(1'b0, 1'b1, 7, 1'b0, 1'b0, 1'b1, 0, "R10 dual up frame with flipped inputs");
    run_frame(1'b1, 1'b1, 8, 1'b0, 1'b0, 1'b0, 0, "R10 single down frame with flipped inputs");
    run_frame(1'b0, 1'b0, 9, 1'b0, 1'b0, 1'b0, 0, "R6 dual down frame R4");
    for (int i = 0; i < 4; i++) drive_slot(1'b0, 12'h0F0, 12'h0E0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #5;
    check(exp_q.size() == 0, "R2 all transfers observed", frame_t'(out_words), last_exp);
    done = 1;
    summary();
    $finish;
  end

endmodule